// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block sits between a host register interface and a three-wire serial EEPROM of 64 sixteen-bit words. The host writes one 16-bit command word that holds a two-bit opcode and a six-bit word address. The controller then produces the whole serial transaction on chip select, serial clock and data out, and samples data in. The host polls a busy bit in the same command register until the transaction ends. Read results, and the value to be written, pass through a separate 16-bit data register.

Write and erase are refused until an erase/write enable command has been issued since reset. A command word written while a transaction is running is dropped. Bit 14 of the command register is a test-mode flag that the host sets with each accepted command and reads back apart from busy. The serial clock runs at the system clock divided by twice the `HALF_DIV` parameter.

Top module: `serial_prom_ctrl`

## Requirements
- R1: Command bits 7:6 select the operation: 2'b10 read, 2'b01 write, 2'b11 erase, each addressing the word given by bits 5:0. Opcode 2'b00 with bits 5:4 = 2'b11 (for example 0x0030) is erase/write enable. Any other 2'b00 word is ignored.
- R2: An accepted command raises chip select on the next clock with data out = 1 (start bit). It then sends the two opcode bits and the six command bits 5:0, MSB first, one bit per serial period. Each period is HALF_DIV clocks with the serial clock low, then HALF_DIV clocks with it high. Data out changes only as the serial clock falls, and it is 0 while chip select is low.
- R3: A write frame has 25 bit periods: the 9 header bits, then the 16 data-register bits MSB first, as they were at acceptance.
- R4: A read frame has 26 bit periods: the 9 header bits, one dummy period, then 16 periods. Data in is sampled as the serial clock falls at the end of each of those 16 periods, MSB first, and data out stays 0 after the header. The assembled word appears in the data register when busy clears.
- R5: Command bit 15 reads as busy from the clock after acceptance until one clock after chip select falls. Chip select falls at the end of the last bit period.
- R6: A command-register write while busy is set is dropped. The transaction in flight and the status read-back are unaffected.
- R7: Write and erase commands are ignored (no frame, busy stays 0, status unchanged) unless an enable command has been accepted since reset.
- R8: Command bit 14 reads as the bit 14 of the last accepted command, and it changes independently of busy.
- R9: Command read bits 7:0 show bits 7:0 of the last accepted command, and bits 13:8 read 0.
- R10: A host data write updates the data register at any time. The data port reads it back. A read result arriving on the same clock takes priority.
- R11: Reset leaves busy, chip select, serial clock, data out, the whole command read-back and the data register at 0, and clears the enable state.
- R12: Erase and enable frames have 9 bit periods (the header only). An erase leaves the addressed word reading 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCmdWe | input | 1 | Command register write strobe |
| hostCmdWdata | input | 16 | Command word written by the host |
| hostCmdRdata | output | 16 | Busy, test-mode flag and last accepted command |
| hostDataWe | input | 1 | Data register write strobe |
| hostDataWdata | input | DATA_W | Data word written by the host |
| hostDataRdata | output | DATA_W | Data register read-back |
| promCs | output | 1 | Serial chip select, active high |
| promSk | output | 1 | Serial clock |
| promDo | output | 1 | Serial data to the EEPROM |
| promDi | input | 1 | Serial data from the EEPROM |

## Verification
The bench holds its own copy of the expected array contents, host registers and serial waveform, and it compares every port on every clock. It attacks the gating of write and erase before enable: a design that skipped the check would run a frame and corrupt a word that the final array comparison flags. It also issues a read while a write is in flight. A controller that took the command would restart the frame or change the status byte. Reads must place the dummy period correctly: a sampler off by one period would return the word shifted by a bit. An erase must finish after nine periods: a frame that is too long would show up as busy staying high longer than expected.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } promOp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DONE  = 2'b10
  } ctlState_e;

  typedef struct packed {
    logic loadFrame;
    logic withData;
    logic shiftOut;
    logic shiftIn;
    logic commitRead;
  } dpStrobe_t;

endpackage

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int CMD_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic [CMD_W-1:0] cmdWord,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             csOut,
  output logic             skOut
);

  localparam int HDR_BITS   = 1 + 2 + ADDR_W;
  localparam int WRITE_BITS = HDR_BITS + DATA_W;
  localparam int READ_BITS  = HDR_BITS + 1 + DATA_W;
  localparam int SLOT_W     = $clog2(READ_BITS + 1);
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  ctlState_e         state;
  promOp_e           opReg;
  promOp_e           cmdOp;
  logic              enabled;
  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] lastSlot;
  logic [SLOT_W-1:0] cmdLastSlot;
  logic [DIV_W-1:0]  divCnt;
  logic              skHigh;
  logic              isEnableCode;
  logic              legal;
  logic              accept;
  logic              halfDone;
  logic              slotEnd;

  always_comb begin
    cmdOp        = promOp_e'(cmdWord[ADDR_W+1:ADDR_W]);
    isEnableCode = (cmdOp == OP_EXT) && (cmdWord[ADDR_W-1 -: 2] == 2'b11);
    legal        = (cmdOp == OP_READ) || isEnableCode ||
                   (((cmdOp == OP_WRITE) || (cmdOp == OP_ERASE)) && enabled);
    accept       = cmdWe && (state == ST_IDLE) && legal;
    halfDone     = (divCnt == DIV_W'(HALF_DIV - 1));
    slotEnd      = (state == ST_SHIFT) && halfDone && skHigh;
    unique case (cmdOp)
      OP_READ:  cmdLastSlot = SLOT_W'(READ_BITS - 1);
      OP_WRITE: cmdLastSlot = SLOT_W'(WRITE_BITS - 1);
      default:  cmdLastSlot = SLOT_W'(HDR_BITS - 1);
    endcase
  end

  always_comb begin
    strobe.loadFrame  = accept;
    strobe.withData   = (cmdOp == OP_WRITE);
    strobe.shiftOut   = slotEnd;
    strobe.shiftIn    = slotEnd && (opReg == OP_READ) && (slotCnt > SLOT_W'(HDR_BITS));
    strobe.commitRead = (state == ST_DONE) && (opReg == OP_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opReg    <= OP_EXT;
      enabled  <= 1'b0;
      slotCnt  <= '0;
      lastSlot <= '0;
      divCnt   <= '0;
      skHigh   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SHIFT;
            opReg    <= cmdOp;
            lastSlot <= cmdLastSlot;
            slotCnt  <= '0;
            divCnt   <= '0;
            skHigh   <= 1'b0;
            if (isEnableCode) enabled <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (halfDone) begin
            divCnt <= '0;
            skHigh <= ~skHigh;
            if (skHigh) begin
              if (slotCnt == lastSlot) state <= ST_DONE;
              else slotCnt <= slotCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign csOut = (state == ST_SHIFT);
  assign skOut = (state == ST_SHIFT) && skHigh;

endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWdata,
  input  logic              serialIn,
  output logic [DATA_W-1:0] dataRdata,
  output logic              testMode,
  output logic [ADDR_W+1:0] lastCmd,
  output logic              serialOut
);

  localparam int FRAME_W  = 1 + 2 + ADDR_W + DATA_W;
  localparam int TEST_BIT = CMD_W - 2;

  logic [FRAME_W-1:0] outShift;
  logic [DATA_W-1:0]  inShift;
  logic [DATA_W-1:0]  dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
    end else if (strobe.loadFrame) begin
      outShift <= {1'b1, cmdWord[ADDR_W+1:0], (strobe.withData ? dataReg : {DATA_W{1'b0}})};
    end else if (strobe.shiftOut) begin
      outShift <= {outShift[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inShift <= '0;
    else if (strobe.shiftIn) inShift <= {inShift[DATA_W-2:0], serialIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else if (strobe.commitRead) dataReg <= inShift;
    else if (dataWe) dataReg <= dataWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testMode <= 1'b0;
      lastCmd  <= '0;
    end else if (strobe.loadFrame) begin
      testMode <= cmdWord[TEST_BIT];
      lastCmd  <= cmdWord[ADDR_W+1:0];
    end
  end

  assign dataRdata = dataReg;
  assign serialOut = outShift[FRAME_W-1];

endmodule

// File: rtl/serial_prom_ctrl.sv
module serial_prom_ctrl
  import spc_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCmdWe,
  input  logic [15:0]       hostCmdWdata,
  output logic [15:0]       hostCmdRdata,
  input  logic              hostDataWe,
  input  logic [DATA_W-1:0] hostDataWdata,
  output logic [DATA_W-1:0] hostDataRdata,
  output logic              promCs,
  output logic              promSk,
  output logic              promDo,
  input  logic              promDi
);

  localparam int CMD_W = 16;
  localparam int PAD_W = CMD_W - 4 - ADDR_W;

  dpStrobe_t         strobe;
  logic              busy;
  logic              csInt;
  logic              skInt;
  logic              testMode;
  logic              serialOut;
  logic [ADDR_W+1:0] lastCmd;
  logic [PAD_W-1:0]  padZero;

  assign padZero = '0;

  spc_control #(
    .HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .cmdWe  (hostCmdWe),
    .cmdWord(hostCmdWdata),
    .strobe (strobe),
    .busy   (busy),
    .csOut  (csInt),
    .skOut  (skInt)
  );

  spc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdWord  (hostCmdWdata),
    .dataWe   (hostDataWe),
    .dataWdata(hostDataWdata),
    .serialIn (promDi),
    .dataRdata(hostDataRdata),
    .testMode (testMode),
    .lastCmd  (lastCmd),
    .serialOut(serialOut)
  );

  assign hostCmdRdata = {busy, testMode, padZero, lastCmd};
  assign promCs       = csInt;
  assign promSk       = skInt;
  assign promDo       = csInt & serialOut;

endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic [7:0] statusLow,
  input logic       cs,
  input logic       sk,
  input logic       dout
);

  // R5: chip select is only ever high inside a busy window
  a_r5_cs_within_busy: assert property (@(posedge clk) disable iff (!rstN)
    cs |-> busy);

  // R5: busy drops only after chip select was already low
  a_r5_busy_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!cs && !$past(cs)));

  // R2: the serial clock toggles only with chip select asserted
  a_r2_sk_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    sk |-> cs);

  // R2: data out holds steady while the serial clock stays high
  a_r2_do_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sk && $past(sk)) |-> $stable(dout));

  // R6: the reported command cannot change in the middle of a transaction
  a_r6_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(statusLow)));

  // R2: data out is quiet whenever chip select is low
  a_r2_do_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> !dout);

endmodule

bind serial_prom_ctrl spc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (hostCmdRdata[15]),
  .statusLow(hostCmdRdata[7:0]),
  .cs       (promCs),
  .sk       (promSk),
  .dout     (promDo)
);

// File: tb/serial_prom_ctrl_tb.sv
`timescale 1ns/1ps
module serial_prom_ctrl_tb;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCmdWe = 1'b0;
  logic [15:0] hostCmdWdata = '0;
  logic [15:0] hostCmdRdata;
  logic        hostDataWe = 1'b0;
  logic [15:0] hostDataWdata = '0;
  logic [15:0] hostDataRdata;
  logic        promCs, promSk, promDo;
  logic        promDi = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_prom_ctrl #(.HALF_DIV(H), .ADDR_W(6), .DATA_W(16)) u_dut (
    .clk(clk), .rstN(rstN),
    .hostCmdWe(hostCmdWe), .hostCmdWdata(hostCmdWdata), .hostCmdRdata(hostCmdRdata),
    .hostDataWe(hostDataWe), .hostDataWdata(hostDataWdata), .hostDataRdata(hostDataRdata),
    .promCs(promCs), .promSk(promSk), .promDo(promDo), .promDi(promDi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM device ----------------
  logic [15:0] devMem [64];
  logic [15:0] memExp [64];
  logic [8:0]  devHdr = '0;
  logic [15:0] devWr = '0;
  int          devCnt = 0;
  bit          devEnabled = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin
      devMem[i] = 16'((i * 16'h0101) ^ 16'h5A3C);
      memExp[i] = 16'((i * 16'h0101) ^ 16'h5A3C);
    end
  end

  always @(posedge promSk) begin
    if (promCs) begin
      int c;
      c = devCnt;
      if (c < 9) devHdr = {devHdr[7:0], promDo};
      else if (devHdr[7:6] == 2'b10) promDi = (c == 9) ? 1'b0 : devMem[devHdr[5:0]][15-(c-10)];
      else if (devHdr[7:6] == 2'b01 && c < 25) devWr = {devWr[14:0], promDo};
      devCnt = c + 1;
      if (devCnt == 9) begin
        if (devHdr[7:6] == 2'b00 && devHdr[5:4] == 2'b11) devEnabled = 1;
        if (devHdr[7:6] == 2'b11 && devEnabled) devMem[devHdr[5:0]] = 16'hFFFF;
      end
      if (devCnt == 25 && devHdr[7:6] == 2'b01 && devEnabled) devMem[devHdr[5:0]] = devWr;
    end
  end

  always @(negedge promCs) begin
    devCnt = 0;
    promDi = 1'b0;
  end

  // ---------------- reference model ----------------
  bit          mActive = 0;
  int          mT = 0;
  int          mN = 0;
  bit          mBits[$];
  logic [1:0]  mOp = '0;
  logic [5:0]  mAddr = '0;
  bit          mEnabled = 0;
  logic        mTest = 1'b0;
  logic [7:0]  mLow = '0;
  logic [15:0] mData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mT = 0; mN = 0; mBits.delete();
      mOp = '0; mAddr = '0; mEnabled = 0; mTest = 0; mLow = '0; mData = '0;
    end else begin
      bit commit;
      commit = 0;
      if (mActive) begin
        mT++;
        if (mT == 2*H*mN + 1) begin
          mActive = 0;
          commit = (mOp == 2'b10);
        end
      end else if (hostCmdWe) begin
        logic [1:0] op;
        bit en, ok;
        op = hostCmdWdata[7:6];
        en = (op == 2'b00) && (hostCmdWdata[5:4] == 2'b11);
        ok = (op == 2'b10) || en || ((op == 2'b01 || op == 2'b11) && mEnabled);
        if (ok) begin
          mActive = 1; mT = 0; mOp = op; mAddr = hostCmdWdata[5:0];
          mTest = hostCmdWdata[14]; mLow = hostCmdWdata[7:0];
          mBits.delete();
          mBits.push_back(1'b1);
          for (int k = 7; k >= 0; k--) mBits.push_back(hostCmdWdata[k]);
          if (op == 2'b01) for (int k = 15; k >= 0; k--) mBits.push_back(mData[k]);
          if (op == 2'b10) for (int k = 0; k < 17; k++) mBits.push_back(1'b0);
          mN = mBits.size();
          if (en) mEnabled = 1;
          if (op == 2'b01) memExp[mAddr] = mData;
          if (op == 2'b11) memExp[mAddr] = 16'hFFFF;
        end
      end
      if (hostDataWe) mData = hostDataWdata;
      if (commit) mData = memExp[mAddr];
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit eCs, eSk, eDo;
      eCs = mActive && (mT < 2*H*mN);
      eSk = eCs && ((mT % (2*H)) >= H);
      eDo = eCs ? mBits[mT/(2*H)] : 1'b0;
      chk(hostCmdRdata[15] == mActive, "R5 busy", 32'(hostCmdRdata[15]), 32'(mActive));
      chk(promCs == eCs, "R2 chip select", 32'(promCs), 32'(eCs));
      chk(promSk == eSk, "R2 serial clock", 32'(promSk), 32'(eSk));
      chk(promDo == eDo, "R2/R3/R4 data out", 32'(promDo), 32'(eDo));
      chk(hostCmdRdata[14:0] == {mTest, 6'b0, mLow}, "R8/R9 status", 32'(hostCmdRdata[14:0]), 32'({mTest, 6'b0, mLow}));
      chk(hostDataRdata == mData, "R4/R10 data register", 32'(hostDataRdata), 32'(mData));
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendCmd(input logic [15:0] w);
    @(negedge clk);
    hostCmdWe = 1'b1; hostCmdWdata = w;
    @(negedge clk);
    hostCmdWe = 1'b0;
  endtask

  task automatic setData(input logic [15:0] d);
    @(negedge clk);
    hostDataWe = 1'b1; hostDataWdata = d;
    @(negedge clk);
    hostDataWe = 1'b0;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (hostCmdRdata[15] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int lim;
    lim = 150000;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > lim) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, lim);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(hostCmdRdata == 16'h0000, "R11 status at reset", 32'(hostCmdRdata), 0);
    chk({promCs, promSk, promDo} == 3'b000, "R11 serial pins at reset", 32'({promCs, promSk, promDo}), 0);
    chk(hostDataRdata == 16'h0000, "R11 data at reset", 32'(hostDataRdata), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: read word 5
    sendCmd(16'h0085);
    waitIdle();
    chk(hostDataRdata == memExp[5], "R4 read word 5", 32'(hostDataRdata), 32'(memExp[5]));

    // R7: write and erase before enable are ignored
    setData(16'h1234);
    sendCmd(16'h0043);
    chk(hostCmdRdata == 16'h0085, "R7 write before enable ignored", 32'(hostCmdRdata), 32'h0085);
    sendCmd(16'h00C7);
    chk(hostCmdRdata[15] == 1'b0, "R7 erase before enable ignored", 32'(hostCmdRdata[15]), 0);

    // R1: an unused 00-opcode word is ignored
    sendCmd(16'h0010);
    chk(hostCmdRdata == 16'h0085, "R1 unused code ignored", 32'(hostCmdRdata), 32'h0085);

    // R12 / R8: enable with test-mode bit set
    sendCmd(16'h4030);
    chk(hostCmdRdata == 16'hC030, "R8 test mode with busy", 32'(hostCmdRdata), 32'hC030);
    waitIdle();
    chk(hostCmdRdata == 16'h4030, "R8 test mode after busy", 32'(hostCmdRdata), 32'h4030);

    // R3: write word 3, with a read attempt in flight (R6)
    setData(16'hBEEF);
    sendCmd(16'h0043);
    repeat (10) @(negedge clk);
    sendCmd(16'h0089);
    chk(hostCmdRdata[7:0] == 8'h43, "R6 command during busy dropped", 32'(hostCmdRdata[7:0]), 32'h43);
    waitIdle();
    chk(devMem[3] == 16'hBEEF, "R3 word 3 written", 32'(devMem[3]), 32'hBEEF);

    sendCmd(16'h0083);
    waitIdle();
    chk(hostDataRdata == 16'hBEEF, "R4 read back word 3", 32'(hostDataRdata), 32'hBEEF);
    sendCmd(16'h00BF);
    waitIdle();
    chk(hostDataRdata == memExp[63], "R4 read word 63", 32'(hostDataRdata), 32'(memExp[63]));

    // R12: erase word 7, read it back
    sendCmd(16'h00C7);
    waitIdle();
    sendCmd(16'h0087);
    waitIdle();
    chk(hostDataRdata == 16'hFFFF, "R12 erased word reads ones", 32'(hostDataRdata), 32'hFFFF);

    // R8: test mode clears with next accepted command
    setData(16'hA5A5);
    sendCmd(16'h0040);
    waitIdle();
    chk(hostCmdRdata[14] == 1'b0, "R8 test mode cleared", 32'(hostCmdRdata[14]), 0);
    sendCmd(16'h0080);
    waitIdle();
    chk(hostDataRdata == 16'hA5A5, "R4 read word 0", 32'(hostDataRdata), 32'hA5A5);

    // R11 / R7: reset clears enable; write afterwards is ignored
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(hostCmdRdata == 16'h0000, "R11 status after second reset", 32'(hostCmdRdata), 0);
    rstN = 1'b1;
    setData(16'h0F0F);
    sendCmd(16'h0041);
    chk(hostCmdRdata[15] == 1'b0, "R7 enable cleared by reset", 32'(hostCmdRdata[15]), 0);
    repeat (4) @(negedge clk);

    for (int i = 0; i < 64; i++)
      chk(devMem[i] == memExp[i], "R3/R7/R12 array contents", 32'(devMem[i]), 32'(memExp[i]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule